// File: doc/BRIEF.md
# Supervisor Mode Sequencer

This block is the mode-sequencing controller of a supervisor chip that sits beside a microcontroller. It keeps one of seven operating modes: Start-up, Restart, Normal, Standby, Sleep, Flash and Fail-safe. For each mode it drives the main regulator enable, the reset line, the enable output, the inhibit control and the operating style of the watchdog. Its inputs are already decoded. These are: a completed serial mode write carrying a 3-bit code and a flag that says whether the frame had exactly 16 clocks, watchdog timeout and window-violation pulses, wake-up pulses, an interrupt-pending level, supply undervoltage and secondary-supply overload levels, oscillator status, and the level seen on the reset pin.

Every time limit is counted in ticks of an internal prescaled clock. A start-up that is never confirmed, a reset pin stuck against its drive, a lasting undervoltage, an unserviced interrupt and the Fail-safe retention time are all measured this way. The mode code values are 111 (Normal), 001 (Standby), 011 (Sleep), 010 (Flash request) and 100 (leave Flash). The codes 000, 101 and 110 are illegal.

Top module: `sbc_mode_ctrl`

## Requirements
- R1: After reset the mode is Start-up (code 0), with regulator on, reset not driven, enable low, inhibit on and watchdog style start-up (1).
- R2: In Start-up or Restart, a 16-clock write of code 111 moves to Normal (code 2).
- R3: A failed start-up moves Start-up to Restart (code 1) and Restart to Fail-safe (code 6). Any of the following is a failure: a frame without 16 clocks, an illegal code, a falling edge on the reset pin, a rising edge on the reset pin while undervoltage is present, or the init timeout.
- R4: Start-up or Restart that stays unconfirmed for INIT_TICKS ticks counts as a failed start-up.
- R5: Outputs per mode (regulator, reset driven low, enable, inhibit, watchdog style with 0 off, 1 start-up, 2 window, 3 timeout). Start-up gives 1,0,0,1,1. Restart gives 1,0,0,0,1. Normal gives 1,0,1,1,2. Standby gives 1,0,0,1,3. Sleep (code 4) gives 0,1,0,0,3. Flash (code 5) gives 1,0,1,1,3. Fail-safe gives 0,1,0,0,0.
- R6: Normal accepts 001 (to Standby, code 3) and 011 (to Sleep). Standby accepts 111 (to Normal) and 011. In Normal, Standby and Flash, a frame without 16 clocks and a wake-up pulse are ignored.
- R7: A Flash request (010) enters Flash only when the last three accepted codes in Normal/Standby were 111, 001, 111 in that order. Otherwise it is ignored.
- R8: Flash returns to Start-up on the leave code 100 or on a watchdog timeout.
- R9: Normal, Standby and Flash return to Start-up on undervoltage, an illegal code, a reset-pin falling edge, or an interrupt pending for INT_TICKS ticks. Normal also returns on a window violation and ignores timeout pulses. Standby also returns on a timeout.
- R10: Sleep returns to Start-up on a wake-up, a watchdog timeout or a secondary-supply overload.
- R11: From any mode other than Fail-safe, the controller enters Fail-safe on any of: oscillator failure; reset pin reading high while driven low for RST_HIGH_TICKS; reset pin reading low while not driven for RST_LOW_TICKS; undervoltage with the regulator on for UV_TICKS.
- R12: Fail-safe leaves for Restart only once a wake-up has been seen in it, the oscillator is good and RET_TICKS ticks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | power-on reset, active low |
| spiWrite | input | 1 | pulse: a mode write frame completed |
| spiCode | input | 3 | mode code of the frame |
| spiBitsOk | input | 1 | frame had exactly 16 clocks |
| wdTimeout | input | 1 | pulse: watchdog timeout |
| wdBadServe | input | 1 | pulse: watchdog window violation |
| wakeUp | input | 1 | pulse: wake-up event |
| intPending | input | 1 | interrupt waiting for service |
| v1Under | input | 1 | main supply undervoltage |
| v3Overload | input | 1 | secondary supply overload |
| oscOk | input | 1 | oscillator good |
| rstPinIn | input | 1 | observed reset pin level |
| mode | output | 3 | current mode code |
| regOn | output | 1 | main regulator enable |
| rstOutLow | output | 1 | drive reset pin low |
| enOut | output | 1 | enable output |
| inhOn | output | 1 | inhibit control |
| wdStyle | output | 2 | watchdog operating style |

## Verification
The table tries each single event from Normal and from Standby. Legal, illegal, short-frame and Flash-request writes show that accepted, rejected and ignored codes are handled apart. Supply, reset-pin and watchdog pulses show which modes react to which kind of watchdog event. Directed runs walk the unlock sequence against a bare Flash request. Held faults are tested against their tick limits, which separates a brief fault from a persistent one. The Fail-safe exit is held back by each missing condition in turn.

// File: rtl/sbc_mode_pkg.sv
package sbc_mode_pkg;
  typedef enum logic [2:0] {
    M_STARTUP  = 3'd0,
    M_RESTART  = 3'd1,
    M_NORMAL   = 3'd2,
    M_STANDBY  = 3'd3,
    M_SLEEP    = 3'd4,
    M_FLASH    = 3'd5,
    M_FAILSAFE = 3'd6
  } mode_e;

  typedef enum logic [1:0] {
    WD_OFF     = 2'd0,
    WD_STARTUP = 2'd1,
    WD_WINDOW  = 2'd2,
    WD_TIMEOUT = 2'd3
  } wdstyle_e;

  localparam logic [2:0] CODE_NORMAL  = 3'b111;
  localparam logic [2:0] CODE_STANDBY = 3'b001;
  localparam logic [2:0] CODE_SLEEP   = 3'b011;
  localparam logic [2:0] CODE_FLASH   = 3'b010;
  localparam logic [2:0] CODE_LEAVE   = 3'b100;

  // strobes from control to datapath
  typedef struct packed {
    logic modeChange;
    logic inStart;
    logic inActive;
    logic inFailsafe;
    logic regOn;
    logic rstDrive;
    logic seqShift;
    logic seqClear;
  } ctrl_t;

  // status from datapath to control
  typedef struct packed {
    logic initExp;
    logic rstHighLong;
    logic rstLowLong;
    logic uvLong;
    logic intLong;
    logic retDone;
    logic wakeSeen;
    logic rstFall;
    logic rstRiseUv;
    logic flashUnlocked;
  } stat_t;

  function automatic logic codeLegal(input logic [2:0] c);
    return (c == CODE_NORMAL) || (c == CODE_STANDBY) || (c == CODE_SLEEP) ||
           (c == CODE_FLASH) || (c == CODE_LEAVE);
  endfunction
endpackage

// File: rtl/sbc_persist_timer.sv
module sbc_persist_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr || !run) begin
      cnt <= '0;
    end else if (tick && cnt < LIM) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/sbc_mode_dp.sv
module sbc_mode_dp
  import sbc_mode_pkg::*;
#(
  parameter int TICK_DIV       = 32,
  parameter int INIT_TICKS     = 256,
  parameter int RST_HIGH_TICKS = 64,
  parameter int RST_LOW_TICKS  = 64,
  parameter int UV_TICKS       = 128,
  parameter int INT_TICKS      = 100,
  parameter int RET_TICKS      = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrl_t      ctrl,
  input  logic [2:0] spiCode,
  input  logic       wakeUp,
  input  logic       v1Under,
  input  logic       rstPinIn,
  input  logic       intPending,
  output stat_t      stat
);
  localparam int NTMR = 6;
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int LIMITS [NTMR] = '{INIT_TICKS, RST_HIGH_TICKS, RST_LOW_TICKS,
                                   UV_TICKS, INT_TICKS, RET_TICKS};

  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_presc
      logic [DW-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (divCnt == DW'(TICK_DIV - 1)) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign tick = (divCnt == DW'(TICK_DIV - 1));
    end else begin : g_nopresc
      assign tick = 1'b1;
    end
  endgenerate

  logic [NTMR-1:0] tmrRun, tmrClr, tmrExp;

  always_comb begin
    tmrRun[0] = ctrl.inStart;
    tmrClr[0] = ctrl.modeChange;
    tmrRun[1] = ctrl.rstDrive && rstPinIn;
    tmrClr[1] = 1'b0;
    tmrRun[2] = !ctrl.rstDrive && !rstPinIn;
    tmrClr[2] = 1'b0;
    tmrRun[3] = v1Under && ctrl.regOn;
    tmrClr[3] = 1'b0;
    tmrRun[4] = intPending && ctrl.inActive;
    tmrClr[4] = ctrl.modeChange;
    tmrRun[5] = ctrl.inFailsafe;
    tmrClr[5] = ctrl.modeChange;
  end

  generate
    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
      sbc_persist_timer #(.LIMIT(LIMITS[i])) u_tmr (
        .clk(clk), .rstN(rstN), .tick(tick),
        .run(tmrRun[i]), .clr(tmrClr[i]), .expired(tmrExp[i])
      );
    end
  endgenerate

  logic       prevPin;
  logic       wakeSeenQ;
  logic [8:0] hist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin   <= 1'b1;
      wakeSeenQ <= 1'b0;
      hist      <= '0;
    end else begin
      prevPin <= rstPinIn;
      if (ctrl.modeChange) begin
        wakeSeenQ <= 1'b0;
      end else if (ctrl.inFailsafe && wakeUp) begin
        wakeSeenQ <= 1'b1;
      end
      if (ctrl.seqClear) begin
        hist <= '0;
      end else if (ctrl.seqShift) begin
        hist <= {hist[5:0], spiCode};
      end
    end
  end

  always_comb begin
    stat.initExp       = tmrExp[0];
    stat.rstHighLong   = tmrExp[1];
    stat.rstLowLong    = tmrExp[2];
    stat.uvLong        = tmrExp[3];
    stat.intLong       = tmrExp[4];
    stat.retDone       = tmrExp[5];
    stat.wakeSeen      = wakeSeenQ;
    stat.rstFall       = prevPin && !rstPinIn;
    stat.rstRiseUv     = !prevPin && rstPinIn && v1Under;
    stat.flashUnlocked = (hist == {CODE_NORMAL, CODE_STANDBY, CODE_NORMAL});
  end
endmodule

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiWrite,
  input  logic [2:0] spiCode,
  input  logic       spiBitsOk,
  input  logic       wdTimeout,
  input  logic       wdBadServe,
  input  logic       wakeUp,
  input  logic       v1Under,
  input  logic       v3Overload,
  input  logic       oscOk,
  input  stat_t      stat,
  output ctrl_t      ctrl,
  output mode_e      modeQ,
  output logic       regOn,
  output logic       rstOutLow,
  output logic       enOut,
  output logic       inhOn,
  output wdstyle_e   wdStyle
);
  mode_e nextMode;
  logic  goodWr, illegalWr, badFrame, fsFault, startFail, activeFail;

  always_comb begin
    goodWr     = spiWrite && spiBitsOk;
    illegalWr  = goodWr && !codeLegal(spiCode);
    badFrame   = spiWrite && !spiBitsOk;
    fsFault    = !oscOk || stat.rstHighLong || stat.rstLowLong || stat.uvLong;
    startFail  = stat.initExp || badFrame || illegalWr || stat.rstFall || stat.rstRiseUv;
    activeFail = v1Under || illegalWr || stat.rstFall || stat.intLong;

    nextMode = modeQ;
    unique case (modeQ)
      M_STARTUP, M_RESTART: begin
        if (startFail) begin
          nextMode = (modeQ == M_STARTUP) ? M_RESTART : M_FAILSAFE;
        end else if (goodWr && spiCode == CODE_NORMAL) begin
          nextMode = M_NORMAL;
        end
      end
      M_NORMAL: begin
        if (activeFail || wdBadServe) begin
          nextMode = M_STARTUP;
        end else if (goodWr) begin
          if (spiCode == CODE_STANDBY) nextMode = M_STANDBY;
          else if (spiCode == CODE_SLEEP) nextMode = M_SLEEP;
          else if (spiCode == CODE_FLASH && stat.flashUnlocked) nextMode = M_FLASH;
        end
      end
      M_STANDBY: begin
        if (activeFail || wdTimeout) begin
          nextMode = M_STARTUP;
        end else if (goodWr) begin
          if (spiCode == CODE_NORMAL) nextMode = M_NORMAL;
          else if (spiCode == CODE_SLEEP) nextMode = M_SLEEP;
          else if (spiCode == CODE_FLASH && stat.flashUnlocked) nextMode = M_FLASH;
        end
      end
      M_FLASH: begin
        if (activeFail || wdTimeout || (goodWr && spiCode == CODE_LEAVE)) begin
          nextMode = M_STARTUP;
        end
      end
      M_SLEEP: begin
        if (wakeUp || wdTimeout || v3Overload) nextMode = M_STARTUP;
      end
      M_FAILSAFE: begin
        if (stat.wakeSeen && oscOk && stat.retDone) nextMode = M_RESTART;
      end
      default: nextMode = M_FAILSAFE;
    endcase

    if (modeQ != M_FAILSAFE && fsFault) nextMode = M_FAILSAFE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= M_STARTUP;
    else       modeQ <= nextMode;
  end

  always_comb begin
    regOn = 1'b1; rstOutLow = 1'b0; enOut = 1'b0; inhOn = 1'b1; wdStyle = WD_STARTUP;
    unique case (modeQ)
      M_STARTUP: ;
      M_RESTART: inhOn = 1'b0;
      M_NORMAL:  begin enOut = 1'b1; wdStyle = WD_WINDOW; end
      M_STANDBY: wdStyle = WD_TIMEOUT;
      M_FLASH:   begin enOut = 1'b1; wdStyle = WD_TIMEOUT; end
      M_SLEEP:   begin regOn = 1'b0; rstOutLow = 1'b1; inhOn = 1'b0; wdStyle = WD_TIMEOUT; end
      default:   begin regOn = 1'b0; rstOutLow = 1'b1; inhOn = 1'b0; wdStyle = WD_OFF; end
    endcase
  end

  always_comb begin
    ctrl.modeChange = (nextMode != modeQ);
    ctrl.inStart    = (modeQ == M_STARTUP) || (modeQ == M_RESTART);
    ctrl.inActive   = (modeQ == M_NORMAL) || (modeQ == M_STANDBY) || (modeQ == M_FLASH);
    ctrl.inFailsafe = (modeQ == M_FAILSAFE);
    ctrl.regOn      = regOn;
    ctrl.rstDrive   = rstOutLow;
    ctrl.seqShift   = goodWr && codeLegal(spiCode) &&
                      ((modeQ == M_NORMAL) || (modeQ == M_STANDBY));
    ctrl.seqClear   = !((nextMode == M_NORMAL) || (nextMode == M_STANDBY));
  end
endmodule

// File: rtl/sbc_mode_ctrl.sv
module sbc_mode_ctrl
  import sbc_mode_pkg::*;
#(
  parameter int TICK_DIV       = 32,
  parameter int INIT_TICKS     = 256,
  parameter int RST_HIGH_TICKS = 64,
  parameter int RST_LOW_TICKS  = 64,
  parameter int UV_TICKS       = 128,
  parameter int INT_TICKS      = 100,
  parameter int RET_TICKS      = 512
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiWrite,
  input  logic [2:0] spiCode,
  input  logic       spiBitsOk,
  input  logic       wdTimeout,
  input  logic       wdBadServe,
  input  logic       wakeUp,
  input  logic       intPending,
  input  logic       v1Under,
  input  logic       v3Overload,
  input  logic       oscOk,
  input  logic       rstPinIn,
  output logic [2:0] mode,
  output logic       regOn,
  output logic       rstOutLow,
  output logic       enOut,
  output logic       inhOn,
  output logic [1:0] wdStyle
);
  ctrl_t    ctrl;
  stat_t    stat;
  mode_e    modeQ;
  wdstyle_e wdS;

  sbc_mode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .spiWrite(spiWrite), .spiCode(spiCode),
    .spiBitsOk(spiBitsOk), .wdTimeout(wdTimeout), .wdBadServe(wdBadServe),
    .wakeUp(wakeUp), .v1Under(v1Under), .v3Overload(v3Overload), .oscOk(oscOk),
    .stat(stat), .ctrl(ctrl), .modeQ(modeQ), .regOn(regOn), .rstOutLow(rstOutLow),
    .enOut(enOut), .inhOn(inhOn), .wdStyle(wdS)
  );

  sbc_mode_dp #(
    .TICK_DIV(TICK_DIV), .INIT_TICKS(INIT_TICKS), .RST_HIGH_TICKS(RST_HIGH_TICKS),
    .RST_LOW_TICKS(RST_LOW_TICKS), .UV_TICKS(UV_TICKS), .INT_TICKS(INT_TICKS),
    .RET_TICKS(RET_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .spiCode(spiCode), .wakeUp(wakeUp),
    .v1Under(v1Under), .rstPinIn(rstPinIn), .intPending(intPending), .stat(stat)
  );

  assign mode    = modeQ;
  assign wdStyle = wdS;
endmodule

// File: rtl/sbc_mode_checker.sv
module sbc_mode_checker
  import sbc_mode_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       spiWrite,
  input logic [2:0] spiCode,
  input logic       spiBitsOk,
  input logic       v1Under,
  input logic       oscOk,
  input logic [2:0] mode,
  input logic       regOn,
  input logic       rstOutLow,
  input logic       enOut
);
  p_sleep_outputs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_SLEEP) |-> (!regOn && rstOutLow && !enOut));

  p_osc_fail_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!oscOk && mode != M_FAILSAFE) |=> (mode == M_FAILSAFE));

  p_failsafe_exit_r12: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_FAILSAFE) |=> (mode == M_FAILSAFE || mode == M_RESTART));

  p_flash_from_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_FLASH && $past(mode) != M_FLASH) |->
      ($past(mode) == M_NORMAL || $past(mode) == M_STANDBY));

  p_normal_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_NORMAL && ($past(mode) == M_STARTUP || $past(mode) == M_RESTART)) |->
      $past(spiWrite && spiBitsOk && spiCode == CODE_NORMAL));

  p_uv_active_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == M_NORMAL || mode == M_STANDBY || mode == M_FLASH) && v1Under) |=>
      (mode == M_STARTUP || mode == M_FAILSAFE));
endmodule

bind sbc_mode_ctrl sbc_mode_checker u_chk (
  .clk(clk), .rstN(rstN), .spiWrite(spiWrite), .spiCode(spiCode),
  .spiBitsOk(spiBitsOk), .v1Under(v1Under), .oscOk(oscOk), .mode(mode),
  .regOn(regOn), .rstOutLow(rstOutLow), .enOut(enOut)
);

// File: tb/sbc_mode_ctrl_bench.sv
module sbc_mode_ctrl_bench;
  import sbc_mode_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiWrite = 1'b0, spiBitsOk = 1'b1;
  logic [2:0] spiCode = 3'b000;
  logic wdTimeout = 1'b0, wdBadServe = 1'b0, wakeUp = 1'b0, intPending = 1'b0;
  logic v1Under = 1'b0, v3Overload = 1'b0, oscOk = 1'b1;
  logic pinForce = 1'b0, pinVal = 1'b1;
  logic rstPinIn;
  logic [2:0] mode;
  logic regOn, rstOutLow, enOut, inhOn;
  logic [1:0] wdStyle;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rstPinIn = pinForce ? pinVal : !rstOutLow;

  sbc_mode_ctrl #(
    .TICK_DIV(2), .INIT_TICKS(20), .RST_HIGH_TICKS(8), .RST_LOW_TICKS(8),
    .UV_TICKS(10), .INT_TICKS(6), .RET_TICKS(5)
  ) u_sbc_mode_ctrl (
    .clk(clk), .rstN(rstN), .spiWrite(spiWrite), .spiCode(spiCode),
    .spiBitsOk(spiBitsOk), .wdTimeout(wdTimeout), .wdBadServe(wdBadServe),
    .wakeUp(wakeUp), .intPending(intPending), .v1Under(v1Under),
    .v3Overload(v3Overload), .oscOk(oscOk), .rstPinIn(rstPinIn), .mode(mode),
    .regOn(regOn), .rstOutLow(rstOutLow), .enOut(enOut), .inhOn(inhOn),
    .wdStyle(wdStyle)
  );

  typedef struct packed {
    logic       stby;
    logic       doSpi;
    logic [2:0] code;
    logic       bitsOk;
    logic       wake;
    logic       wdTo;
    logic       wdBad;
    logic       uv;
    logic       pinLow;
    logic [2:0] expMode;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b1,3'b001,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_STANDBY,4'd6}, // R6
    '{1'b0,1'b1,3'b011,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_SLEEP,  4'd6}, // R6
    '{1'b0,1'b1,3'b001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,M_NORMAL, 4'd6}, // R6 short frame
    '{1'b0,1'b1,3'b000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_STARTUP,4'd9}, // R9 illegal
    '{1'b0,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,M_STARTUP,4'd9}, // R9 uv
    '{1'b0,1'b0,3'b000,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,M_STARTUP,4'd9}, // R9 pin fall
    '{1'b0,1'b0,3'b000,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,M_STARTUP,4'd9}, // R9 window
    '{1'b0,1'b0,3'b000,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,M_NORMAL, 4'd9}, // R9 timeout ignored
    '{1'b1,1'b0,3'b000,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,M_STARTUP,4'd9}, // R9 standby timeout
    '{1'b1,1'b1,3'b111,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_NORMAL, 4'd6}, // R6
    '{1'b1,1'b1,3'b010,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_STANDBY,4'd7}, // R7 locked
    '{1'b1,1'b0,3'b000,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,M_STANDBY,4'd6}, // R6 wake ignored
    '{1'b0,1'b1,3'b010,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_NORMAL, 4'd7}, // R7 locked
    '{1'b1,1'b1,3'b101,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,M_STARTUP,4'd9}  // R9 illegal
  };

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkOuts(input int m, input int r, input int rl, input int e,
                         input int ih, input int w, input string req);
    chk(mode, m, req, "mode");
    chk({28'd0, regOn, rstOutLow, enOut, inhOn}, (r << 3) | (rl << 2) | (e << 1) | ih,
        req, "regOn/rstOutLow/enOut/inhOn");
    chk(wdStyle, w, req, "wdStyle");
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; spiWrite = 1'b0; spiBitsOk = 1'b1; spiCode = 3'b000;
    wdTimeout = 1'b0; wdBadServe = 1'b0; wakeUp = 1'b0; intPending = 1'b0;
    v1Under = 1'b0; v3Overload = 1'b0; oscOk = 1'b1; pinForce = 1'b0; pinVal = 1'b1;
    cyc(3);
    rstN = 1'b1;
  endtask

  task automatic spiWr(input logic [2:0] c, input logic ok);
    @(negedge clk);
    spiWrite = 1'b1; spiCode = c; spiBitsOk = ok;
    @(negedge clk);
    spiWrite = 1'b0; spiBitsOk = 1'b1;
  endtask

  task automatic waitMode(input logic [2:0] m, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (mode == m) break;
      @(negedge clk);
    end
  endtask

  task automatic goNormal();
    doReset();
    spiWr(CODE_NORMAL, 1'b1);
  endtask

  task automatic goFlash();
    goNormal();
    spiWr(CODE_NORMAL, 1'b1);
    spiWr(CODE_STANDBY, 1'b1);
    spiWr(CODE_NORMAL, 1'b1);
    spiWr(CODE_FLASH, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state, R5 Start-up outputs
    doReset();
    cyc(1);
    chkOuts(M_STARTUP, 1, 0, 0, 1, WD_STARTUP, "R1");

    // table walk from Normal / Standby
    for (int v = 0; v < NVEC; v++) begin
      goNormal();
      if (VECS[v].stby) spiWr(CODE_STANDBY, 1'b1);
      @(negedge clk);
      spiWrite = VECS[v].doSpi; spiCode = VECS[v].code; spiBitsOk = VECS[v].bitsOk;
      wakeUp = VECS[v].wake; wdTimeout = VECS[v].wdTo; wdBadServe = VECS[v].wdBad;
      v1Under = VECS[v].uv; pinForce = VECS[v].pinLow; pinVal = 1'b0;
      @(negedge clk);
      spiWrite = 1'b0; spiBitsOk = 1'b1; wakeUp = 1'b0; wdTimeout = 1'b0;
      wdBadServe = 1'b0; v1Under = 1'b0; pinForce = 1'b0;
      chk(mode, VECS[v].expMode, $sformatf("R%0d", VECS[v].req), $sformatf("vector %0d", v));
    end

    // R4 / R3 init timeout chain, R5 Restart and Fail-safe outputs
    doReset();
    cyc(30);
    chk(mode, M_STARTUP, "R4", "before init timeout");
    waitMode(M_RESTART, 30);
    chkOuts(M_RESTART, 1, 0, 0, 0, WD_STARTUP, "R4");
    cyc(30);
    chk(mode, M_RESTART, "R3", "restart before timeout");
    waitMode(M_FAILSAFE, 30);
    chkOuts(M_FAILSAFE, 0, 1, 0, 0, WD_OFF, "R3");

    // R12 fail-safe exit
    cyc(20);
    chk(mode, M_FAILSAFE, "R12", "no wake seen");
    oscOk = 1'b0;
    wakeUp = 1'b1; @(negedge clk); wakeUp = 1'b0;
    cyc(5);
    chk(mode, M_FAILSAFE, "R12", "oscillator bad");
    oscOk = 1'b1;
    cyc(2);
    chk(mode, M_RESTART, "R12", "all conditions met");
    spiWr(CODE_NORMAL, 1'b1);
    chkOuts(M_NORMAL, 1, 0, 1, 1, WD_WINDOW, "R2");

    // R3 short frame and illegal code in Start-up
    doReset();
    spiWr(CODE_NORMAL, 1'b0);
    chk(mode, M_RESTART, "R3", "short frame in start-up");
    doReset();
    spiWr(3'b110, 1'b1);
    chk(mode, M_RESTART, "R3", "illegal code in start-up");

    // R3 reset rising with undervoltage in Restart
    doReset();
    @(negedge clk); v1Under = 1'b1; pinForce = 1'b1; pinVal = 1'b0;
    @(negedge clk); pinForce = 1'b0;
    chk(mode, M_RESTART, "R3", "pin fall in start-up");
    @(negedge clk);
    chk(mode, M_FAILSAFE, "R3", "pin rise with undervoltage in restart");
    v1Under = 1'b0;

    // R7 flash unlock, R5 Flash outputs, R8 exits
    goFlash();
    chkOuts(M_FLASH, 1, 0, 1, 1, WD_TIMEOUT, "R7");
    spiWr(CODE_NORMAL, 1'b1);
    chk(mode, M_FLASH, "R8", "other code ignored in flash");
    spiWr(CODE_LEAVE, 1'b1);
    chk(mode, M_STARTUP, "R8", "leave code");
    goFlash();
    @(negedge clk); wdTimeout = 1'b1; @(negedge clk); wdTimeout = 1'b0;
    chk(mode, M_STARTUP, "R8", "timeout in flash");

    // R5 Standby outputs
    goNormal();
    spiWr(CODE_STANDBY, 1'b1);
    chkOuts(M_STANDBY, 1, 0, 0, 1, WD_TIMEOUT, "R5");

    // R10 sleep exits
    for (int k = 0; k < 3; k++) begin
      goNormal();
      spiWr(CODE_SLEEP, 1'b1);
      chkOuts(M_SLEEP, 0, 1, 0, 0, WD_TIMEOUT, "R5");
      cyc(2);
      chk(mode, M_SLEEP, "R10", "sleep idle");
      @(negedge clk);
      wakeUp = (k == 0); wdTimeout = (k == 1); v3Overload = (k == 2);
      @(negedge clk);
      wakeUp = 1'b0; wdTimeout = 1'b0; v3Overload = 1'b0;
      chk(mode, M_STARTUP, "R10", $sformatf("sleep exit %0d", k));
    end

    // R9 interrupt unserviced
    goNormal();
    intPending = 1'b1;
    cyc(6);
    chk(mode, M_NORMAL, "R9", "interrupt short");
    waitMode(M_STARTUP, 20);
    chk(mode, M_STARTUP, "R9", "interrupt too long");
    intPending = 1'b0;

    // R11 fail-safe triggers
    goNormal();
    @(negedge clk); oscOk = 1'b0; @(negedge clk); oscOk = 1'b1;
    chk(mode, M_FAILSAFE, "R11", "oscillator fail");
    goNormal();
    pinForce = 1'b1; pinVal = 1'b0;
    waitMode(M_FAILSAFE, 40);
    chk(mode, M_FAILSAFE, "R11", "reset pin low too long");
    pinForce = 1'b0;
    goNormal();
    spiWr(CODE_SLEEP, 1'b1);
    pinForce = 1'b1; pinVal = 1'b1;
    cyc(4);
    chk(mode, M_SLEEP, "R11", "reset pin high briefly");
    waitMode(M_FAILSAFE, 40);
    chk(mode, M_FAILSAFE, "R11", "reset pin high too long");
    pinForce = 1'b0;
    goNormal();
    v1Under = 1'b1;
    cyc(2);
    chk(mode, M_STARTUP, "R9", "undervoltage leaves normal");
    waitMode(M_FAILSAFE, 40);
    chk(mode, M_FAILSAFE, "R11", "undervoltage too long");
    v1Under = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule